// File: doc/BRIEF.md
# Debug Emulator Mode Controller

This block keeps track of whether a processor core is running in emulator mode. It also produces the side effects of that mode for the rest of the core. Three events can start the mode:

- a reset-release strobe that arrives while the force-at-reset control bit is set;
- the start of debug interrupt exception processing;
- the start of trace exception processing while the trace-to-emulator control bit is set.

Only a completed exception return ends the mode. All outputs are registered. Each output changes on the clock edge that samples its triggering input.

While emulator mode is active, the block blocks every incoming interrupt request, including the non-maskable level 7. It disables the on-chip RAM. When the mapped-space bit is set, it also forces bus accesses into a dedicated address space and disables caching. The override also covers the access presented in the same cycle as the entry event. The block substitutes one-cycle status codes for mode entry and mode exit into the processor status stream. It also presents the debug exception vector number.

Top module: `emu_mode_ctrl`

## Requirements
- R1: While `rst_i` is high and on the edge after it, every output is zero.
- R2: A `rst_rel_i` pulse while `force_emu_i` is 1 sets `emu_o` on the next clock edge.
- R3: `force_emu_i` has no effect on `emu_o` unless `rst_rel_i` is high in the same cycle, whether the block is inside or outside the mode.
- R4: A `dbg_irq_i` pulse sets `emu_o` on the next edge. In the cycle after that edge, `vec_o` reads 12. At all other times `vec_o` reads 0.
- R5: A `trace_exc_i` pulse enters the mode only when `trace_emu_en_i` is 1. Otherwise the pulse is ignored.
- R6: `emu_o` clears only on the edge that samples `rte_i` high. A `rte_i` pulse outside the mode has no effect.
- R7: If an entry event and `rte_i` occur in the same cycle, the entry event wins. `emu_o` is then 1 and `pst_o` is 0xD.
- R8: One cycle after an input, `irq_req_o` and `irq_lvl_o` copy `irq_req_i` and `irq_lvl_i`. If the next mode state is emulator mode, both read 0 instead, even for level 7.
- R9: When the next mode state is emulator mode and `map_en_i` is 1, the registered overrides are `tt_o` = 2, `tm_o` = 6 for an instruction fetch (`fetch_i` = 1) or 5 for a data access, and `cache_dis_o` = 1. Otherwise `tt_i` and `tm_i` pass through and `cache_dis_o` = 0.
- R10: `sram_dis_o` is 1 exactly when the mode is active, whatever `map_en_i` is.
- R11: `pst_o` reads 0xD for one cycle after an entry event and 0x7 for one cycle after an exit. Otherwise it repeats `pst_i` with a one-cycle delay.
- R12: A `dbg_irq_i` in the cycle right after an exit enters the mode again and produces 0xD again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rst_rel_i | input | 1 | Strobe: reset exception processing begins |
| force_emu_i | input | 1 | Control bit: enter the mode at reset release |
| trace_emu_en_i | input | 1 | Control bit: trace exceptions enter the mode |
| map_en_i | input | 1 | Control bit: mapped address space in the mode |
| dbg_irq_i | input | 1 | Debug interrupt exception processing begins |
| trace_exc_i | input | 1 | Trace exception processing begins |
| rte_i | input | 1 | Exception return completes |
| irq_lvl_i | input | 3 | Incoming interrupt level |
| irq_req_i | input | 1 | Incoming interrupt request |
| fetch_i | input | 1 | Current access is an instruction fetch |
| tt_i | input | 2 | Normal transfer type |
| tm_i | input | 3 | Normal transfer modifier |
| pst_i | input | 4 | Normal processor status code |
| emu_o | output | 1 | Emulator mode active |
| irq_lvl_o | output | 3 | Interrupt level after masking |
| irq_req_o | output | 1 | Interrupt request after masking |
| tt_o | output | 2 | Transfer type to the bus |
| tm_o | output | 3 | Transfer modifier to the bus |
| cache_dis_o | output | 1 | Cache disable |
| sram_dis_o | output | 1 | On-chip RAM disable |
| pst_o | output | 4 | Processor status code |
| vec_o | output | 8 | Debug exception vector number |

## Verification
The assertions check these rules on every cycle:

- the mode rises only after an entry event and falls only after an exception return;
- interrupts stay blocked, and the RAM stays disabled, while the mode is active;
- the mapped-space overrides hold whenever the mode and the mapped-space bit are both active;
- the status code equals 0xD on each mode rise and 0x7 on each mode fall.

Some behaviours only the bench scenarios can show:

- the force-at-reset bit being ignored away from reset release;
- an entry event winning over a return in the same cycle;
- re-entry straight after a return;
- the fetch-versus-data choice of modifier for the access in the entry cycle;
- the one-cycle pass-through of the normal status code.

// File: rtl/emu_pkg.sv
package emu_pkg;
  localparam int unsigned LVL_W_D = 3;
  localparam int unsigned TT_W_D  = 2;
  localparam int unsigned TM_W_D  = 3;
  localparam int unsigned PST_W_D = 4;
  localparam int unsigned VEC_W_D = 8;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_RESET = 2'd1,
    CAUSE_DEBUG = 2'd2,
    CAUSE_TRACE = 2'd3
  } emu_cause_e;
endpackage

// File: rtl/emu_mode_track.sv
module emu_mode_track
  import emu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       rst_rel_i,
  input  logic       force_emu_i,
  input  logic       trace_emu_en_i,
  input  logic       dbg_irq_i,
  input  logic       trace_exc_i,
  input  logic       rte_i,
  output logic       emu_q_o,
  output logic       emu_nxt_o,
  output emu_cause_e cause_o,
  output logic       leave_o
);
  logic from_reset, from_trace, any_entry;

  // The force bit only counts when reset exception processing starts.
  assign from_reset = rst_rel_i & force_emu_i;
  assign from_trace = trace_exc_i & trace_emu_en_i;
  assign any_entry  = from_reset | dbg_irq_i | from_trace;

  // Debug takes precedence when reporting the cause (it selects the vector).
  always_comb begin
    if (dbg_irq_i)       cause_o = CAUSE_DEBUG;
    else if (from_trace) cause_o = CAUSE_TRACE;
    else if (from_reset) cause_o = CAUSE_RESET;
    else                 cause_o = CAUSE_NONE;
  end

  // Entry wins over a simultaneous return.
  assign leave_o   = emu_q_o & rte_i & ~any_entry;
  assign emu_nxt_o = any_entry | (emu_q_o & ~rte_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) emu_q_o <= 1'b0;
    else       emu_q_o <= emu_nxt_o;
  end
endmodule

// File: rtl/emu_irq_gate.sv
module emu_irq_gate #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             emu_nxt_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             irq_req_i,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic             irq_req_o
);
  // Every level is blocked in the mode, the top level included.
  always_ff @(posedge clk_i) begin
    if (rst_i || emu_nxt_i) begin
      irq_lvl_o <= '0;
      irq_req_o <= 1'b0;
    end else begin
      irq_lvl_o <= irq_lvl_i;
      irq_req_o <= irq_req_i;
    end
  end
endmodule

// File: rtl/emu_bus_override.sv
module emu_bus_override #(
  parameter int unsigned TT_W        = 2,
  parameter int unsigned TM_W        = 3,
  parameter logic [TT_W-1:0] TT_EMU  = 2,
  parameter logic [TM_W-1:0] TM_DATA = 5,
  parameter logic [TM_W-1:0] TM_FTCH = 6
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            emu_nxt_i,
  input  logic            map_en_i,
  input  logic            fetch_i,
  input  logic [TT_W-1:0] tt_i,
  input  logic [TM_W-1:0] tm_i,
  output logic [TT_W-1:0] tt_o,
  output logic [TM_W-1:0] tm_o,
  output logic            cache_dis_o,
  output logic            sram_dis_o
);
  logic            mapped;
  logic [TM_W-1:0] tm_emu;

  // The next state is used so that the access in the entry cycle is covered.
  assign mapped = emu_nxt_i & map_en_i;
  assign tm_emu = fetch_i ? TM_FTCH : TM_DATA;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tt_o        <= '0;
      tm_o        <= '0;
      cache_dis_o <= 1'b0;
      sram_dis_o  <= 1'b0;
    end else begin
      tt_o        <= mapped ? TT_EMU : tt_i;
      tm_o        <= mapped ? tm_emu : tm_i;
      cache_dis_o <= mapped;
      sram_dis_o  <= emu_nxt_i;
    end
  end
endmodule

// File: rtl/emu_pst_gen.sv
module emu_pst_gen
  import emu_pkg::*;
#(
  parameter int unsigned PST_W = 4,
  parameter int unsigned VEC_W = 8,
  parameter logic [PST_W-1:0] PST_ENTER = 4'hD,
  parameter logic [PST_W-1:0] PST_LEAVE = 4'h7,
  parameter logic [VEC_W-1:0] DBG_VEC   = 8'd12
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  emu_cause_e       cause_i,
  input  logic             leave_i,
  input  logic [PST_W-1:0] pst_i,
  output logic [PST_W-1:0] pst_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pst_o <= '0;
      vec_o <= '0;
    end else begin
      if (cause_i != CAUSE_NONE) pst_o <= PST_ENTER;
      else if (leave_i)          pst_o <= PST_LEAVE;
      else                       pst_o <= pst_i;
      vec_o <= (cause_i == CAUSE_DEBUG) ? DBG_VEC : '0;
    end
  end
endmodule

// File: rtl/emu_mode_ctrl.sv
module emu_mode_ctrl
  import emu_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_D,
  parameter int unsigned TT_W  = TT_W_D,
  parameter int unsigned TM_W  = TM_W_D,
  parameter int unsigned PST_W = PST_W_D,
  parameter int unsigned VEC_W = VEC_W_D,
  parameter int unsigned DBG_VEC      = 12,
  parameter int unsigned PST_ENTER    = 13,
  parameter int unsigned PST_LEAVE    = 7,
  parameter int unsigned TT_EMU       = 2,
  parameter int unsigned TM_EMU_DATA  = 5,
  parameter int unsigned TM_EMU_FETCH = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             rst_rel_i,
  input  logic             force_emu_i,
  input  logic             trace_emu_en_i,
  input  logic             map_en_i,
  input  logic             dbg_irq_i,
  input  logic             trace_exc_i,
  input  logic             rte_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             irq_req_i,
  input  logic             fetch_i,
  input  logic [TT_W-1:0]  tt_i,
  input  logic [TM_W-1:0]  tm_i,
  input  logic [PST_W-1:0] pst_i,
  output logic             emu_o,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic             irq_req_o,
  output logic [TT_W-1:0]  tt_o,
  output logic [TM_W-1:0]  tm_o,
  output logic             cache_dis_o,
  output logic             sram_dis_o,
  output logic [PST_W-1:0] pst_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [PST_W-1:0] PST_ENTER_C = PST_W'(PST_ENTER);
  localparam logic [PST_W-1:0] PST_LEAVE_C = PST_W'(PST_LEAVE);
  localparam logic [VEC_W-1:0] DBG_VEC_C   = VEC_W'(DBG_VEC);
  localparam logic [TT_W-1:0]  TT_EMU_C    = TT_W'(TT_EMU);
  localparam logic [TM_W-1:0]  TM_DATA_C   = TM_W'(TM_EMU_DATA);
  localparam logic [TM_W-1:0]  TM_FTCH_C   = TM_W'(TM_EMU_FETCH);

  logic       emu_q, emu_nxt, leave;
  emu_cause_e cause;

  emu_mode_track u_track (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .rst_rel_i      (rst_rel_i),
    .force_emu_i    (force_emu_i),
    .trace_emu_en_i (trace_emu_en_i),
    .dbg_irq_i      (dbg_irq_i),
    .trace_exc_i    (trace_exc_i),
    .rte_i          (rte_i),
    .emu_q_o        (emu_q),
    .emu_nxt_o      (emu_nxt),
    .cause_o        (cause),
    .leave_o        (leave)
  );

  emu_irq_gate #(.LVL_W(LVL_W)) u_irq (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .emu_nxt_i (emu_nxt),
    .irq_lvl_i (irq_lvl_i),
    .irq_req_i (irq_req_i),
    .irq_lvl_o (irq_lvl_o),
    .irq_req_o (irq_req_o)
  );

  emu_bus_override #(
    .TT_W(TT_W), .TM_W(TM_W), .TT_EMU(TT_EMU_C),
    .TM_DATA(TM_DATA_C), .TM_FTCH(TM_FTCH_C)
  ) u_bus (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .emu_nxt_i   (emu_nxt),
    .map_en_i    (map_en_i),
    .fetch_i     (fetch_i),
    .tt_i        (tt_i),
    .tm_i        (tm_i),
    .tt_o        (tt_o),
    .tm_o        (tm_o),
    .cache_dis_o (cache_dis_o),
    .sram_dis_o  (sram_dis_o)
  );

  emu_pst_gen #(
    .PST_W(PST_W), .VEC_W(VEC_W), .PST_ENTER(PST_ENTER_C),
    .PST_LEAVE(PST_LEAVE_C), .DBG_VEC(DBG_VEC_C)
  ) u_pst (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cause_i (cause),
    .leave_i (leave),
    .pst_i   (pst_i),
    .pst_o   (pst_o),
    .vec_o   (vec_o)
  );

  assign emu_o = emu_q;
endmodule

// File: rtl/emu_mode_ctrl_chk.sv
module emu_mode_ctrl_chk #(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned TT_W  = 2,
  parameter int unsigned TM_W  = 3,
  parameter int unsigned PST_W = 4,
  parameter int unsigned PST_ENTER    = 13,
  parameter int unsigned PST_LEAVE    = 7,
  parameter int unsigned TT_EMU       = 2,
  parameter int unsigned TM_EMU_DATA  = 5,
  parameter int unsigned TM_EMU_FETCH = 6
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             rst_rel_i,
  input logic             force_emu_i,
  input logic             trace_emu_en_i,
  input logic             map_en_i,
  input logic             dbg_irq_i,
  input logic             trace_exc_i,
  input logic             rte_i,
  input logic             emu_o,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic             irq_req_o,
  input logic [TT_W-1:0]  tt_o,
  input logic [TM_W-1:0]  tm_o,
  input logic             cache_dis_o,
  input logic             sram_dis_o,
  input logic [PST_W-1:0] pst_o
);
  // R2
  entry_sets_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((rst_rel_i && force_emu_i) || dbg_irq_i || (trace_exc_i && trace_emu_en_i)) |=> emu_o);

  // R3
  rise_needs_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(emu_o) |-> $past((rst_rel_i && force_emu_i) || dbg_irq_i || (trace_exc_i && trace_emu_en_i)));

  // R6
  fall_needs_rte_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(emu_o) |-> $past(rte_i));

  // R8
  irq_blocked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    emu_o |-> (!irq_req_o && irq_lvl_o == '0));

  // R9
  mapped_space_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (emu_o && $past(map_en_i)) |->
      (tt_o == TT_W'(TT_EMU) && cache_dis_o &&
       (tm_o == TM_W'(TM_EMU_DATA) || tm_o == TM_W'(TM_EMU_FETCH))));

  // R10
  sram_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    emu_o |-> sram_dis_o);

  // R11
  enter_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(emu_o) |-> pst_o == PST_W'(PST_ENTER));

  // R11
  leave_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(emu_o) |-> pst_o == PST_W'(PST_LEAVE));
endmodule

bind emu_mode_ctrl emu_mode_ctrl_chk #(
  .LVL_W(LVL_W), .TT_W(TT_W), .TM_W(TM_W), .PST_W(PST_W),
  .PST_ENTER(PST_ENTER), .PST_LEAVE(PST_LEAVE), .TT_EMU(TT_EMU),
  .TM_EMU_DATA(TM_EMU_DATA), .TM_EMU_FETCH(TM_EMU_FETCH)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .rst_rel_i(rst_rel_i),
  .force_emu_i(force_emu_i), .trace_emu_en_i(trace_emu_en_i),
  .map_en_i(map_en_i), .dbg_irq_i(dbg_irq_i), .trace_exc_i(trace_exc_i),
  .rte_i(rte_i), .emu_o(emu_o), .irq_lvl_o(irq_lvl_o), .irq_req_o(irq_req_o),
  .tt_o(tt_o), .tm_o(tm_o), .cache_dis_o(cache_dis_o),
  .sram_dis_o(sram_dis_o), .pst_o(pst_o)
);

// File: tb/emu_mode_ctrl_tb.sv
module emu_mode_ctrl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, rst_rel, force_emu, trace_en, map_en, dbg_irq, trace_exc, rte;
  logic [2:0] irq_lvl, tm_in;
  logic       irq_req, fetch;
  logic [1:0] tt_in;
  logic [3:0] pst_in;

  logic       emu, irq_req_q, cache_dis, sram_dis;
  logic [2:0] irq_lvl_q, tm_q;
  logic [1:0] tt_q;
  logic [3:0] pst_q;
  logic [7:0] vec_q;

  emu_mode_ctrl u_dut (
    .clk_i(clk), .rst_i(rst), .rst_rel_i(rst_rel), .force_emu_i(force_emu),
    .trace_emu_en_i(trace_en), .map_en_i(map_en), .dbg_irq_i(dbg_irq),
    .trace_exc_i(trace_exc), .rte_i(rte), .irq_lvl_i(irq_lvl),
    .irq_req_i(irq_req), .fetch_i(fetch), .tt_i(tt_in), .tm_i(tm_in),
    .pst_i(pst_in), .emu_o(emu), .irq_lvl_o(irq_lvl_q), .irq_req_o(irq_req_q),
    .tt_o(tt_q), .tm_o(tm_q), .cache_dis_o(cache_dis), .sram_dis_o(sram_dis),
    .pst_o(pst_q), .vec_o(vec_q)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Behavioural reference, stepped on each rising edge.
  int m_emu, m_req, m_lvl, m_tt, m_tm, m_cache, m_sram, m_pst, m_vec;
  always @(posedge clk) begin
    if (rst) begin
      m_emu = 0; m_req = 0; m_lvl = 0; m_tt = 0; m_tm = 0;
      m_cache = 0; m_sram = 0; m_pst = 0; m_vec = 0;
    end else begin
      int entering, leaving, nxt;
      entering = (rst_rel && force_emu) || dbg_irq || (trace_exc && trace_en);
      leaving  = !entering && rte && m_emu;
      nxt      = entering ? 1 : (rte ? 0 : m_emu);
      m_pst    = entering ? 13 : (leaving ? 7 : pst_in);
      m_vec    = dbg_irq ? 12 : 0;
      m_req    = nxt ? 0 : irq_req;
      m_lvl    = nxt ? 0 : irq_lvl;
      m_cache  = nxt && map_en;
      m_tt     = m_cache ? 2 : tt_in;
      m_tm     = m_cache ? (fetch ? 6 : 5) : tm_in;
      m_sram   = nxt;
      m_emu    = nxt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("R2 emu_o", emu, m_emu);
    chk("R8 irq_req_o", irq_req_q, m_req);
    chk("R8 irq_lvl_o", irq_lvl_q, m_lvl);
    chk("R9 tt_o", tt_q, m_tt);
    chk("R9 tm_o", tm_q, m_tm);
    chk("R9 cache_dis_o", cache_dis, m_cache);
    chk("R10 sram_dis_o", sram_dis, m_sram);
    chk("R11 pst_o", pst_q, m_pst);
    chk("R4 vec_o", vec_q, m_vec);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare_all();
    rst_rel = 0; dbg_irq = 0; trace_exc = 0; rte = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1; rst_rel = 0; force_emu = 0; trace_en = 0; map_en = 0;
    dbg_irq = 0; trace_exc = 0; rte = 0; irq_lvl = 0; irq_req = 0;
    fetch = 0; tt_in = 0; tm_in = 0; pst_in = 0;
    cyc(); cyc();
    // R1: reset state
    chk("R1 emu_o", emu, 0); chk("R1 pst_o", pst_q, 0); chk("R1 tt_o", tt_q, 0);
    chk("R1 sram_dis_o", sram_dis, 0); chk("R1 vec_o", vec_q, 0);
    rst = 0;
    // Normal pass-through, level 7 request
    irq_lvl = 7; irq_req = 1; tt_in = 1; tm_in = 3; pst_in = 4'h2;
    cyc();
    chk("R8 pass lvl", irq_lvl_q, 7); chk("R11 pass pst", pst_q, 2);
    // R3: force bit without reset release
    force_emu = 1; cyc(); cyc();
    chk("R3 force alone", emu, 0);
    // R2: reset release with force bit
    rst_rel = 1; cyc();
    chk("R2 enter", emu, 1); chk("R11 code D", pst_q, 13);
    chk("R8 lvl7 blocked", irq_req_q, 0);
    cyc();
    chk("R11 one cycle", pst_q, 2);
    // R10 without map, R3 force toggle in mode
    force_emu = 0; tm_in = 4; cyc();
    chk("R10 sram", sram_dis, 1); chk("R9 no map tt", tt_q, 1); chk("R3 in mode", emu, 1);
    map_en = 1; fetch = 0; cyc();
    chk("R9 data tm", tm_q, 5); chk("R9 tt", tt_q, 2);
    fetch = 1; cyc();
    chk("R9 fetch tm", tm_q, 6);
    // R6: exit
    rte = 1; cyc();
    chk("R6 exit", emu, 0); chk("R11 code 7", pst_q, 7); chk("R8 restored", irq_req_q, 1);
    rte = 1; cyc();
    chk("R6 rte outside", pst_q, 2);
    // R5: trace with and without enable
    trace_exc = 1; cyc();
    chk("R5 trace ignored", emu, 0);
    trace_en = 1; trace_exc = 1; cyc();
    chk("R5 trace entry", emu, 1);
    // R7: entry and return together
    dbg_irq = 1; rte = 1; cyc();
    chk("R7 entry wins", emu, 1); chk("R7 pst", pst_q, 13); chk("R4 vector", vec_q, 12);
    cyc();
    chk("R4 vector clears", vec_q, 0);
    // R12: re-entry straight after return
    rte = 1; cyc();
    chk("R12 left", emu, 0);
    dbg_irq = 1; fetch = 1; cyc();
    chk("R12 re-entered", emu, 1); chk("R12 pst", pst_q, 13);
    chk("R9 entry access", tm_q, 6);
    rte = 1; map_en = 0; cyc();
    // Mixed pattern sweep
    for (int i = 0; i < 200; i++) begin
      dbg_irq = (i % 17) == 3; trace_exc = (i % 11) == 5; trace_en = (i % 3) != 0;
      rte = (i % 7) == 2; rst_rel = (i % 23) == 9; force_emu = (i % 2) == 0;
      map_en = (i % 5) < 3; fetch = (i % 4) == 1; irq_req = (i % 3) == 1;
      irq_lvl = 3'(i); tt_in = 2'(i >> 1); tm_in = 3'(i >> 2); pst_in = 4'(i * 5);
      cyc();
    end
    finish_run();
  end
endmodule